// File: doc/BRIEF.md
# Alarm, Timer and Interrupt Controller for a BCD Clock/Calendar

This block sits beside the counter chain of a clock/calendar and turns its counts into two status flags and one interrupt line. When alarm operation is switched off, the two flags are not event flags. Instead they act as free-running square waves with a 50% duty cycle: one has a period of one second and the other a period of one minute. A separate BCD timer byte counts whole days in this state.

When alarm operation is switched on, an alarm control byte takes over. It chooses the unit the timer counts in, from hundredths of a second up to days. It also chooses whether a clock alarm is armed, and of which kind: daily, on selected weekdays, or on a full date. A further bit arms a timer alarm, and two bits decide which flags are allowed to pull the interrupt low. The flags are sticky. They change only when an event sets them or when a bus write to the status byte loads them.

The counter chain supplies one strobe for each unit together with the current count values. The strobe is high in the cycle in which the new count is already present on the value inputs. The alarm comparison bytes come from register storage outside this block.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, both flags are 0, the timer value is 8'h00 and int_n is 1.
- R2: With alarm_en low, one cycle after each clock edge timer_flag equals (cur_hsec >= 8'h50) and alarm_flag equals (cur_sec >= 8'h30). Status writes have no effect and int_n stays 1.
- R3: With alarm_en low, the timer advances by one BCD step on each tick_day and never sets timer_flag.
- R4: With alarm_en high, the timer advances on the strobe chosen by alm_ctrl[2:0]: 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 days. Codes 5 to 7 stop it.
- R5: The timer counts in packed BCD. A step from 8'h99 yields 8'h00 and, with alarm_en high, sets timer_flag.
- R6: With alarm_en high and alm_ctrl[6] set, a timer step whose new value equals alm_timer sets alarm_flag.
- R7: With alarm_en high, alm_ctrl[5:4] selects the clock alarm: 00 none, 01 daily, 11 dated. On tick_hs the alarm fires when hundredths, seconds, minutes and hours all equal their alarm bytes; a dated alarm also needs the date and month to match.
- R8: Type 10 is a weekday alarm. It fires on a time match when cur_wday is 0 to 6 and bit cur_wday of alm_wdmask is 1.
- R9: With alarm_en high, a flag stays set until st_wr loads it from st_wdata (bit 0 timer, bit 1 alarm). A set event in the same cycle as the write leaves the flag at 1.
- R10: tmr_wr loads tmr_wdata into the timer on the next edge. In that cycle the load takes priority over a step.
- R11: int_n is 0 exactly when alarm_en is high and either (alarm_flag and alm_ctrl[7]) or (timer_flag and alm_ctrl[3]).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alarm_en | input | 1 | Alarm operation enable from the status byte |
| tick_hs | input | 1 | Hundredths count updated this cycle |
| tick_sec | input | 1 | Seconds count updated this cycle |
| tick_min | input | 1 | Minutes count updated this cycle |
| tick_hour | input | 1 | Hours count updated this cycle |
| tick_day | input | 1 | Day count updated this cycle |
| cur_hsec | input | 8 | Current hundredths, BCD |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours byte |
| cur_date | input | 8 | Current date, BCD |
| cur_month | input | 8 | Current month, BCD |
| cur_wday | input | 3 | Current weekday 0..6 |
| alm_ctrl | input | 8 | Alarm control byte |
| alm_hsec | input | 8 | Alarm hundredths |
| alm_sec | input | 8 | Alarm seconds |
| alm_min | input | 8 | Alarm minutes |
| alm_hour | input | 8 | Alarm hours byte |
| alm_date | input | 8 | Alarm date |
| alm_month | input | 8 | Alarm month |
| alm_wdmask | input | 7 | Weekday enable mask |
| alm_timer | input | 8 | Timer alarm compare value |
| st_wr | input | 1 | Status byte write strobe |
| st_wdata | input | 2 | Flag values written |
| tmr_wr | input | 1 | Timer write strobe |
| tmr_wdata | input | 8 | Timer value written |
| timer_value | output | 8 | Timer count, BCD |
| timer_flag | output | 1 | Timer flag |
| alarm_flag | output | 1 | Alarm flag |
| int_n | output | 1 | Active-low interrupt, to an open-drain pad |

## Verification
The hardest condition to reach is a dated alarm. It needs a hundredths strobe in a cycle where six count bytes all equal their alarm bytes at once. A weekday alarm is almost as rare, because it also needs the right bit in the weekday mask. The stimulus therefore drives each count byte to its alarm value three times out of four. It also loads the timer close to 99 and close to the timer compare value, so that overflows and timer alarms happen in every segment that uses them. Segments then change the control byte so that every unit code and every alarm type is covered, with the alarm disabled at the start and at the end.

// File: rtl/alarm_irq_pkg.sv
// Shared constants, types and the BCD step used by the alarm controller.
// Assumes 8-bit packed BCD bytes (two digits).
package alarm_irq_pkg;
    localparam int BYTE_W    = 8;
    localparam int WDAY_N    = 7;
    localparam int UNIT_N    = 5;
    localparam int UNIT_W    = 3;
    localparam int CTL_AIE   = 7;
    localparam int CTL_TALM  = 6;
    localparam int CTL_TYPE  = 4;
    localparam int CTL_TIE   = 3;
    localparam logic [BYTE_W-1:0] HALF_SEC = 8'h50;
    localparam logic [BYTE_W-1:0] HALF_MIN = 8'h30;
    localparam logic [BYTE_W-1:0] BCD_MAX  = 8'h99;

    typedef enum logic [1:0] {
        ATYPE_NONE    = 2'b00,
        ATYPE_DAILY   = 2'b01,
        ATYPE_WEEKDAY = 2'b10,
        ATYPE_DATED   = 2'b11
    } atype_e;

    // Two-digit BCD increment, 99 wraps to 00.
    function automatic logic [BYTE_W-1:0] bcd_inc(input logic [BYTE_W-1:0] v);
        logic [3:0] lo, hi;
        lo = v[3:0];
        hi = v[7:4];
        if (lo == 4'd9) begin
            lo = 4'd0;
            hi = (hi == 4'd9) ? 4'd0 : hi + 4'd1;
        end else begin
            lo = lo + 4'd1;
        end
        return {hi, lo};
    endfunction
endpackage

// File: rtl/alarm_match.sv
// Clock alarm comparator: reports a hit on a hundredths strobe when the
// time (and date or weekday, per type) equals the alarm bytes.
// Assumes the count inputs already hold the new value while tick_hs is high.
module alarm_match
    import alarm_irq_pkg::*;
(
    input  logic              tick_hs,
    input  atype_e            atype,
    input  logic [BYTE_W-1:0] cur_hsec,
    input  logic [BYTE_W-1:0] cur_sec,
    input  logic [BYTE_W-1:0] cur_min,
    input  logic [BYTE_W-1:0] cur_hour,
    input  logic [BYTE_W-1:0] cur_date,
    input  logic [BYTE_W-1:0] cur_month,
    input  logic [2:0]        cur_wday,
    input  logic [BYTE_W-1:0] alm_hsec,
    input  logic [BYTE_W-1:0] alm_sec,
    input  logic [BYTE_W-1:0] alm_min,
    input  logic [BYTE_W-1:0] alm_hour,
    input  logic [BYTE_W-1:0] alm_date,
    input  logic [BYTE_W-1:0] alm_month,
    input  logic [WDAY_N-1:0] alm_wdmask,
    output logic              hit
);
    logic time_eq, date_eq, day_ok;
    logic [WDAY_N-1:0] day_sel;

    // Field equality and weekday selection.
    always_comb begin
        time_eq = (cur_hsec == alm_hsec) && (cur_sec == alm_sec) &&
                  (cur_min == alm_min) && (cur_hour == alm_hour);
        date_eq = (cur_date == alm_date) && (cur_month == alm_month);
        day_sel = WDAY_N'(1) << cur_wday;
        day_ok  = (cur_wday < 3'(WDAY_N)) && |(alm_wdmask & day_sel);
    end

    // Combine per alarm type.
    always_comb begin
        unique case (atype)
            ATYPE_DAILY:   hit = tick_hs && time_eq;
            ATYPE_WEEKDAY: hit = tick_hs && time_eq && day_ok;
            ATYPE_DATED:   hit = tick_hs && time_eq && date_eq;
            default:       hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/bcd_timer.sv
// BCD timer byte with selectable step strobe, write load, overflow and
// compare events. Assumes written values are valid BCD.
module bcd_timer
    import alarm_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic [UNIT_W-1:0] unit,
    input  logic [UNIT_N-1:0] ticks,
    input  logic              wr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              cmp_en,
    input  logic [BYTE_W-1:0] cmp_val,
    output logic [BYTE_W-1:0] value,
    output logic              step,
    output logic              ovf_evt,
    output logic              cmp_evt
);
    logic [BYTE_W-1:0] nxt;
    logic [UNIT_W-1:0] eff_unit;

    // Pick the strobe for the active unit; days when alarm is off.
    always_comb begin
        eff_unit = run_en ? unit : UNIT_W'(UNIT_N - 1);
        step = 1'b0;
        for (int i = 0; i < UNIT_N; i++) begin
            if (eff_unit == UNIT_W'(i)) step = ticks[i];
        end
        nxt     = bcd_inc(value);
        ovf_evt = run_en && step && !wr && (value == BCD_MAX);
        cmp_evt = run_en && cmp_en && step && !wr && (nxt == cmp_val);
    end

    // Timer register: load beats step.
    always_ff @(posedge clk) begin
        if (!rst_n)    value <= '0;
        else if (wr)   value <= wdata;
        else if (step) value <= nxt;
    end
endmodule

// File: rtl/flag_irq.sv
// Timer/alarm flags and the active-low interrupt. Flags follow square
// waves when alarm operation is off, and are sticky when it is on.
module flag_irq
    import alarm_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       alarm_en,
    input  logic       sec_half,
    input  logic       min_half,
    input  logic       st_wr,
    input  logic [1:0] st_wdata,
    input  logic       t_set,
    input  logic       a_set,
    input  logic       t_ie,
    input  logic       a_ie,
    output logic       timer_flag,
    output logic       alarm_flag,
    output logic       int_n
);
    // Flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timer_flag <= 1'b0;
            alarm_flag <= 1'b0;
        end else if (!alarm_en) begin
            timer_flag <= sec_half;
            alarm_flag <= min_half;
        end else begin
            timer_flag <= (st_wr ? st_wdata[0] : timer_flag) | t_set;
            alarm_flag <= (st_wr ? st_wdata[1] : alarm_flag) | a_set;
        end
    end

    // Interrupt request, low when an enabled flag is up.
    always_comb begin
        int_n = !(alarm_en && ((alarm_flag && a_ie) || (timer_flag && t_ie)));
    end
endmodule

// File: rtl/alarm_irq_ctrl.sv
// Top of the alarm/timer/interrupt controller. Decodes the alarm control
// byte and ties comparator, timer and flag logic together.
// Assumes strobes are high in the cycle the new counts are presented.
module alarm_irq_ctrl
    import alarm_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alarm_en,
    input  logic              tick_hs,
    input  logic              tick_sec,
    input  logic              tick_min,
    input  logic              tick_hour,
    input  logic              tick_day,
    input  logic [BYTE_W-1:0] cur_hsec,
    input  logic [BYTE_W-1:0] cur_sec,
    input  logic [BYTE_W-1:0] cur_min,
    input  logic [BYTE_W-1:0] cur_hour,
    input  logic [BYTE_W-1:0] cur_date,
    input  logic [BYTE_W-1:0] cur_month,
    input  logic [2:0]        cur_wday,
    input  logic [BYTE_W-1:0] alm_ctrl,
    input  logic [BYTE_W-1:0] alm_hsec,
    input  logic [BYTE_W-1:0] alm_sec,
    input  logic [BYTE_W-1:0] alm_min,
    input  logic [BYTE_W-1:0] alm_hour,
    input  logic [BYTE_W-1:0] alm_date,
    input  logic [BYTE_W-1:0] alm_month,
    input  logic [WDAY_N-1:0] alm_wdmask,
    input  logic [BYTE_W-1:0] alm_timer,
    input  logic              st_wr,
    input  logic [1:0]        st_wdata,
    input  logic              tmr_wr,
    input  logic [BYTE_W-1:0] tmr_wdata,
    output logic [BYTE_W-1:0] timer_value,
    output logic              timer_flag,
    output logic              alarm_flag,
    output logic              int_n
);
    atype_e            atype;
    logic [UNIT_N-1:0] ticks;
    logic              clk_hit, tmr_step, tmr_ovf, tmr_cmp;

    // Control byte decode and strobe bundling.
    always_comb begin
        atype = atype_e'(alm_ctrl[CTL_TYPE+1:CTL_TYPE]);
        ticks = {tick_day, tick_hour, tick_min, tick_sec, tick_hs};
    end

    alarm_match u_match (
        .tick_hs   (tick_hs && alarm_en),
        .atype     (atype),
        .cur_hsec  (cur_hsec),
        .cur_sec   (cur_sec),
        .cur_min   (cur_min),
        .cur_hour  (cur_hour),
        .cur_date  (cur_date),
        .cur_month (cur_month),
        .cur_wday  (cur_wday),
        .alm_hsec  (alm_hsec),
        .alm_sec   (alm_sec),
        .alm_min   (alm_min),
        .alm_hour  (alm_hour),
        .alm_date  (alm_date),
        .alm_month (alm_month),
        .alm_wdmask(alm_wdmask),
        .hit       (clk_hit)
    );

    bcd_timer u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (alarm_en),
        .unit    (alm_ctrl[UNIT_W-1:0]),
        .ticks   (ticks),
        .wr      (tmr_wr),
        .wdata   (tmr_wdata),
        .cmp_en  (alm_ctrl[CTL_TALM]),
        .cmp_val (alm_timer),
        .value   (timer_value),
        .step    (tmr_step),
        .ovf_evt (tmr_ovf),
        .cmp_evt (tmr_cmp)
    );

    flag_irq u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .alarm_en  (alarm_en),
        .sec_half  (cur_hsec >= HALF_SEC),
        .min_half  (cur_sec >= HALF_MIN),
        .st_wr     (st_wr),
        .st_wdata  (st_wdata),
        .t_set     (tmr_ovf),
        .a_set     (clk_hit || tmr_cmp),
        .t_ie      (alm_ctrl[CTL_TIE]),
        .a_ie      (alm_ctrl[CTL_AIE]),
        .timer_flag(timer_flag),
        .alarm_flag(alarm_flag),
        .int_n     (int_n)
    );
endmodule

// File: rtl/alarm_irq_ctrl_chk.sv
// Property checker for alarm_irq_ctrl, attached with bind below.
module alarm_irq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       alarm_en,
    input logic [7:0] cur_hsec,
    input logic       st_wr,
    input logic       tmr_wr,
    input logic [7:0] tmr_wdata,
    input logic       tmr_step,
    input logic [7:0] timer_value,
    input logic       timer_flag,
    input logic       alarm_flag,
    input logic       int_n
);
    a_r11_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !alarm_en |-> int_n);

    a_r9_alarm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_en && alarm_flag && !st_wr |=> alarm_flag);

    a_r9_timer_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_en && timer_flag && !st_wr |=> timer_flag);

    a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_en && tmr_step && !tmr_wr && timer_value == 8'h99
        |=> timer_value == 8'h00 && timer_flag);

    a_r2_sec_square: assert property (@(posedge clk) disable iff (!rst_n)
        !alarm_en |=> timer_flag == ($past(cur_hsec) >= 8'h50));

    a_r10_load: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_wr |=> timer_value == $past(tmr_wdata));
endmodule

bind alarm_irq_ctrl alarm_irq_ctrl_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .alarm_en   (alarm_en),
    .cur_hsec   (cur_hsec),
    .st_wr      (st_wr),
    .tmr_wr     (tmr_wr),
    .tmr_wdata  (tmr_wdata),
    .tmr_step   (tmr_step),
    .timer_value(timer_value),
    .timer_flag (timer_flag),
    .alarm_flag (alarm_flag),
    .int_n      (int_n)
);

// File: tb/test_alarm_irq_ctrl.sv
module test_alarm_irq_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alarm_en = 1'b0;
    logic tick_hs = 1'b0, tick_sec = 1'b0, tick_min = 1'b0, tick_hour = 1'b0, tick_day = 1'b0;
    logic [7:0] cur_hsec = '0, cur_sec = '0, cur_min = '0, cur_hour = '0, cur_date = '0, cur_month = '0;
    logic [2:0] cur_wday = '0;
    logic [7:0] alm_ctrl = '0;
    logic [7:0] alm_hsec = 8'h25, alm_sec = 8'h41, alm_min = 8'h07, alm_hour = 8'h13;
    logic [7:0] alm_date = 8'h19, alm_month = 8'h06, alm_timer = 8'h03;
    logic [6:0] alm_wdmask = 7'b0101010;
    logic st_wr = 1'b0;
    logic [1:0] st_wdata = '0;
    logic tmr_wr = 1'b0;
    logic [7:0] tmr_wdata = '0;
    logic [7:0] timer_value;
    logic timer_flag, alarm_flag, int_n;

    int checks = 0;
    int errors = 0;
    int m_tv = 0;
    bit m_tf = 0, m_af = 0;

    always #2 clk = ~clk;

    alarm_irq_ctrl i_alarm_irq_ctrl (.*);

    function automatic int binc(int v);
        int n;
        n = (v >> 4) * 10 + (v & 15);
        n = (n + 1) % 100;
        return ((n / 10) << 4) | (n % 10);
    endfunction

    function automatic int to_bcd(int n);
        return ((n / 10) << 4) | (n % 10);
    endfunction

    // Behavioural reference, advanced on every rising edge.
    always @(posedge clk) begin
        bit step, et, ea, tm;
        int nv;
        if (!rst_n) begin
            m_tv = 0; m_tf = 0; m_af = 0;
        end else if (!alarm_en) begin
            m_tf = (cur_hsec >= 8'h50);
            m_af = (cur_sec >= 8'h30);
            if (tmr_wr) m_tv = tmr_wdata;
            else if (tick_day) m_tv = binc(m_tv);
        end else begin
            et = 0; ea = 0;
            case (alm_ctrl[2:0])
                3'd0: step = tick_hs;
                3'd1: step = tick_sec;
                3'd2: step = tick_min;
                3'd3: step = tick_hour;
                3'd4: step = tick_day;
                default: step = 0;
            endcase
            if (tmr_wr) m_tv = tmr_wdata;
            else if (step) begin
                nv = binc(m_tv);
                if (m_tv == 'h99) et = 1;
                if (alm_ctrl[6] && nv == alm_timer) ea = 1;
                m_tv = nv;
            end
            tm = (cur_hsec == alm_hsec) && (cur_sec == alm_sec) &&
                 (cur_min == alm_min) && (cur_hour == alm_hour);
            if (tick_hs && tm) begin
                case (alm_ctrl[5:4])
                    2'b01: ea = 1;
                    2'b10: if (cur_wday < 7 && alm_wdmask[cur_wday]) ea = 1;
                    2'b11: if (cur_date == alm_date && cur_month == alm_month) ea = 1;
                    default: ;
                endcase
            end
            m_tf = (st_wr ? st_wdata[0] : m_tf) | et;
            m_af = (st_wr ? st_wdata[1] : m_af) | ea;
        end
    end

    task automatic check(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        bit exp_int;
        exp_int = !(alarm_en && ((m_af && alm_ctrl[7]) || (m_tf && alm_ctrl[3])));
        check("R3/R4/R5/R10 timer_value", timer_value, m_tv);
        check("R2/R5/R9 timer_flag", timer_flag, m_tf);
        check("R2/R6/R7/R8/R9 alarm_flag", alarm_flag, m_af);
        check("R11 int_n", int_n, exp_int);
    endtask

    function automatic logic [7:0] pick(logic [7:0] target);
        if ($urandom_range(3) != 0) return target;
        return 8'(to_bcd($urandom_range(99)));
    endfunction

    task automatic drive_random(bit en, logic [7:0] ctrl);
        int r;
        alarm_en  = en;
        alm_ctrl  = ctrl;
        tick_hs   = ($urandom_range(2) == 0);
        tick_sec  = ($urandom_range(2) == 0);
        tick_min  = ($urandom_range(2) == 0);
        tick_hour = ($urandom_range(2) == 0);
        tick_day  = ($urandom_range(2) == 0);
        cur_hsec  = en ? pick(alm_hsec) : 8'(to_bcd($urandom_range(99)));
        cur_sec   = en ? pick(alm_sec)  : 8'(to_bcd($urandom_range(59)));
        cur_min   = pick(alm_min);
        cur_hour  = pick(alm_hour);
        cur_date  = pick(alm_date);
        cur_month = pick(alm_month);
        cur_wday  = 3'($urandom_range(7));
        st_wr     = ($urandom_range(15) == 0);
        st_wdata  = 2'($urandom_range(3));
        tmr_wr    = ($urandom_range(31) == 0);
        r = $urandom_range(4);
        tmr_wdata = (r == 0) ? 8'h97 : (r == 1) ? 8'h98 : (r == 2) ? 8'h99 :
                    (r == 3) ? 8'h01 : 8'(to_bcd($urandom_range(99)));
    endtask

    initial begin
        logic [7:0] ctl [8];
        bit         ena [8];
        ctl = '{8'h00, 8'h88, 8'hC9, 8'h9A, 8'hA3, 8'hBC, 8'h8D, 8'h00};
        ena = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 timer_value", timer_value, 0);
        check("R1 timer_flag", timer_flag, 0);
        check("R1 alarm_flag", alarm_flag, 0);
        check("R1 int_n", int_n, 1);
        rst_n = 1'b1;
        for (int s = 0; s < 8; s++) begin
            for (int c = 0; c < 600; c++) begin
                drive_random(ena[s], ctl[s]);
                @(negedge clk);
                compare_all();
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule